// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is a small synchronous up-counter with four bits by default. It has a parallel preset, two count enables and a look-ahead carry output, so that several copies can be chained into a wider counter. The count changes only on a rising clock edge. The exception is the clear: a build-time parameter selects whether the active-low reset acts at once or waits for the clock edge.

To chain stages, every stage gets the same clock and the same `en_count`. The lowest stage ties `en_carry` high. Each more significant stage takes its `en_carry` from the `carry_out` of the stage below it. `carry_out` is a plain gate of `en_carry` with the all-ones count, so the carry reaches the top of the chain within one cycle and no stage depends on a registered ripple.

When the clear is inactive, the load has priority over counting, and counting has priority over holding. The count wraps from all ones back to zero.

Top module: `cnt_stage`

## Requirements
- R1: While `rst_n` is low, the count goes to 0, whatever the levels of `load_n`, `din`, `en_count` and `en_carry`.
- R2: With `SYNC_RESET` = 0, a low `rst_n` clears the count at once, without a clock edge. With `SYNC_RESET` = 1, the count keeps its value until the next rising edge and clears on that edge.
- R3: With `rst_n` high and `load_n` low, a rising edge copies `din` into the count.
- R4: With `rst_n` and `load_n` high and both `en_count` and `en_carry` high, a rising edge adds one to the count. All ones wraps to 0.
- R5: With `rst_n` and `load_n` high and either enable low, a rising edge leaves the count unchanged.
- R6: `carry_out` is high exactly when `en_carry` is high, the count is all ones and `rst_n` is high. It follows `en_carry` within the same cycle, without a clock edge, and `en_count` has no effect on it.
- R7: `carry_out` is low whenever `rst_n` is low, even in the synchronous variant while the count still holds all ones.
- R8: When `load_n` is low and both enables are high on the same edge, the load wins: the count becomes `din`, not the count plus one.
- R9: Loading all ones while `en_carry` is high raises `carry_out` in the cycle after that load edge.
- R10: In two chained stages, with the low stage's `carry_out` driving the high stage's `en_carry` and a shared `en_count`, the pair counts as one 8-bit value and rolls over from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low clear; acts at once or on the clock edge, set by `SYNC_RESET` |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset value |
| en_count | input | 1 | Count enable shared by all stages of a chain |
| en_carry | input | 1 | Count enable that also gates `carry_out`; in a chain it comes from the stage below |
| count | output | WIDTH | Current count, registered |
| carry_out | output | 1 | Look-ahead terminal-count output for the next stage |

## Verification
Two pairs of operations can fall on the same edge. A load can arrive while both enables are high, and a clear can arrive while a load is pending and both enables are high. The bench drives each load with both enables set, so every load edge is also a possible count edge. The load is judged correct only if the count equals `din` and not `din` plus one. The clear is driven together with an active load and active enables, and it is judged by a zero count on both reset variants. A clear is also dropped in the middle of a cycle while the count holds all ones, to tell the immediate clear from the clocked one and to show that `carry_out` falls at once in both.

// File: rtl/cnt_stage_pkg.sv
package cnt_stage_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INCR  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/cnt_stage_ctrl.sv
module cnt_stage_ctrl
  import cnt_stage_pkg::*;
(
  input  logic    rst_n,
  input  logic    load_n,
  input  logic    en_count,
  input  logic    en_carry,
  output cnt_op_e op
);

  // Priority: clear, then load, then increment, then hold.
  always_comb begin
    if (!rst_n)
      op = OP_CLEAR;
    else if (!load_n)
      op = OP_LOAD;
    else if (en_count && en_carry)
      op = OP_INCR;
    else
      op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_stage_reg.sv
module cnt_stage_reg
  import cnt_stage_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SYNC_RESET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_INCR:  q_nxt = q + ONE;
      default:  q_nxt = q;
    endcase
  end

  generate
    if (SYNC_RESET != 0) begin : g_sync_clr
      always_ff @(posedge clk) begin
        q <= q_nxt;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else
          q <= q_nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_stage_carry.sv
module cnt_stage_carry #(
  parameter int WIDTH = 4
) (
  input  logic             rst_n,
  input  logic             en_carry,
  input  logic [WIDTH-1:0] q,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Look-ahead carry: combinational in en_carry, masked while clearing.
  assign carry_out = rst_n && en_carry && (q == ALL_ONES);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_stage_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SYNC_RESET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_count,
  input  logic             en_carry,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  cnt_op_e op;

  cnt_stage_ctrl u_ctrl (
    .rst_n    (rst_n),
    .load_n   (load_n),
    .en_count (en_count),
    .en_carry (en_carry),
    .op       (op)
  );

  cnt_stage_reg #(
    .WIDTH      (WIDTH),
    .SYNC_RESET (SYNC_RESET)
  ) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (din),
    .q     (count)
  );

  cnt_stage_carry #(
    .WIDTH (WIDTH)
  ) u_carry (
    .rst_n     (rst_n),
    .en_carry  (en_carry),
    .q         (count),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/cnt_stage_chk.sv
module cnt_stage_chk #(
  parameter int WIDTH      = 4,
  parameter int SYNC_RESET = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_count,
  input logic             en_carry,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  assert_clear_R1: assert property (@(posedge clk)
    !rst_n |=> count == '0);

  generate
    if (SYNC_RESET == 0) begin : g_async_chk
      assert_async_clear_R2: assert property (@(posedge clk)
        !rst_n |-> count == '0);
    end
  endgenerate

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(din));

  assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_count && en_carry) |=> count == $past(count) + ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_count && en_carry)) |=> $stable(count));

  assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_carry && count == ALL_ONES));

  assert_carry_clr_R7: assert property (@(posedge clk)
    !rst_n |-> !carry_out);

  assert_load_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && din == ALL_ONES && en_carry) |=> (en_carry |-> carry_out));

endmodule

bind cnt_stage cnt_stage_chk #(
  .WIDTH      (WIDTH),
  .SYNC_RESET (SYNC_RESET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .din       (din),
  .en_count  (en_count),
  .en_carry  (en_carry),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/tb_cnt_stage.sv
module tb_cnt_stage;

  localparam int CLK_P = 10;
  localparam int W     = 4;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Shared stimulus for the async (dut) and sync (dut_sync) variants
  logic         rst_n, load_n, en_c, en_k;
  logic [W-1:0] din;
  logic [W-1:0] cnt_a, cnt_s;
  logic         co_a, co_s;

  cnt_stage #(.WIDTH(W), .SYNC_RESET(0)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_count(en_c), .en_carry(en_k), .count(cnt_a), .carry_out(co_a));

  cnt_stage #(.WIDTH(W), .SYNC_RESET(1)) dut_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_count(en_c), .en_carry(en_k), .count(cnt_s), .carry_out(co_s));

  // Two-stage chain
  logic         c_rst_n, c_load_n, c_en;
  logic [7:0]   c_din;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_co, hi_co;

  cnt_stage #(.WIDTH(W), .SYNC_RESET(1)) u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[3:0]),
    .en_count(c_en), .en_carry(1'b1), .count(lo_q), .carry_out(lo_co));

  cnt_stage #(.WIDTH(W), .SYNC_RESET(1)) u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[7:4]),
    .en_count(c_en), .en_carry(lo_co), .count(hi_q), .carry_out(hi_co));

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q;
  logic [7:0]   exp_c;

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Advance one edge; the models use the inputs held across that edge.
  task automatic tick();
    @(posedge clk);
    if (!rst_n)                exp_q = '0;
    else if (!load_n)          exp_q = din;
    else if (en_c && en_k)     exp_q = exp_q + 1'b1;
    if (!c_rst_n)              exp_c = '0;
    else if (!c_load_n)        exp_c = c_din;
    else if (c_en)             exp_c = exp_c + 8'd1;
    #1;
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1; load_n = 1; en_c = 0; en_k = 0; din = '0;
    c_rst_n = 1; c_load_n = 1; c_en = 0; c_din = '0;
    exp_q = '0; exp_c = '0;
    #1;
    rst_n = 0; c_rst_n = 0;
    tick();
    chk("R1 async reset count", int'(cnt_a), 0);
    chk("R1 sync reset count", int'(cnt_s), 0);

    // R1: clear wins over an active load and active enables
    load_n = 0; din = 4'd9; en_c = 1; en_k = 1;
    tick();
    chk("R1 clear over load async", int'(cnt_a), 0);
    chk("R1 clear over load sync", int'(cnt_s), 0);
    chk("R7 carry low in reset", int'(co_a), 0);
    rst_n = 1; c_rst_n = 1; load_n = 1;

    // Sweep every preset value, then a stretch of mixed enable patterns
    for (int v = 0; v < 16; v++) begin
      load_n = 0; din = W'(v); en_c = 1; en_k = 1;
      tick();
      chk("R8 load wins over count", int'(cnt_a), v);
      chk("R3 load sync", int'(cnt_s), v);
      chk("R9 carry after load", int'(co_a), (v == 15) ? 1 : 0);
      load_n = 1;
      for (int j = 0; j < 20; j++) begin
        en_c = ((v + j) % 3) != 0;
        en_k = ((v * j + j) % 4) != 0;
        #1;
        chk("R6 carry follows en_carry", int'(co_a), (en_k && exp_q == 4'hF) ? 1 : 0);
        chk("R6 carry sync", int'(co_s), (en_k && exp_q == 4'hF) ? 1 : 0);
        tick();
        chk((en_c && en_k) ? "R4 increment" : "R5 hold", int'(cnt_a), int'(exp_q));
        chk((en_c && en_k) ? "R4 increment sync" : "R5 hold sync", int'(cnt_s), int'(exp_q));
      end
    end

    // R2 / R7: clear dropped mid-cycle while the count is all ones
    load_n = 0; din = 4'hF; en_k = 1; en_c = 0;
    tick();
    load_n = 1;
    chk("R9 carry after loading ones", int'(co_s), 1);
    rst_n = 0;
    #1;
    chk("R2 async clears at once", int'(cnt_a), 0);
    chk("R2 sync waits for edge", int'(cnt_s), 15);
    chk("R7 sync carry low in reset", int'(co_s), 0);
    chk("R7 async carry low in reset", int'(co_a), 0);
    tick();
    chk("R2 sync clears on edge", int'(cnt_s), 0);
    rst_n = 1;

    // R10: two-stage chain, 8-bit count with pauses
    for (int i = 0; i < 300; i++) begin
      c_en = (i % 7) != 6;
      tick();
      chk("R10 chained count", int'({hi_q, lo_q}), int'(exp_c));
    end
    c_load_n = 0; c_din = 8'hFE; c_en = 1;
    tick();
    c_load_n = 1;
    chk("R10 chain load", int'({hi_q, lo_q}), 254);
    tick();
    chk("R10 chain at 255", int'({hi_q, lo_q}), 255);
    chk("R10 top carry at 255", int'(hi_co), 1);
    tick();
    chk("R10 chain rollover", int'({hi_q, lo_q}), 0);
    chk("R10 top carry after rollover", int'(hi_co), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule